// File: doc/BRIEF.md
# Vector Chaining Issue Sequencer

This block decides when vector instructions may start on three functional units (load, multiply, add) that share one vector register file, and when each of those units may read its next source element. Decoded instructions arrive one at a time in program order; each names a unit, a destination register and up to two source registers, and it covers the number of elements given by the vector length input at the moment it is granted. The arithmetic and memory datapaths stay outside. They take the per-unit read strobes and the element index from the sequencer. After their own pipeline delay (six stages for the multiplier, a few for the adder and the loader) they return one writeback pulse per element.

For every vector register the sequencer keeps a busy flag and a count of elements already written by the instruction that is producing it. With chaining switched on, a consumer reads element k as soon as the count passes k, so a dependent multiply or add streams right behind its producer. With chaining switched off, the consumer holds until the producer's final element has landed. A unit that has finished an instruction stays closed for a fixed dead time before the next instruction may enter it. The three units run concurrently, so unrelated instructions overlap.

Top module: `vcs_chain_seq`

## Requirements
- R1: At most one instruction is granted per cycle, strictly in program order. `grant` is high only while `in_valid` is high, and an instruction that is not granted is held at the input until it is.
- R2: Unit code 0 selects the load unit, 1 the multiplier and 2 the adder. Code 3 is reserved and is never granted. A grant needs the selected unit to be free.
- R3: An instruction stalls while its destination register is busy with an earlier producer. It also stalls while any unit that is still reading elements uses that register as a source.
- R4: With `chain_en` high, a unit may read element k of a busy source only once that source's written-element count exceeds k. The first read of a dependent instruction can come in the cycle right after the producer's first writeback.
- R5: With `chain_en` low, a unit never reads from a busy source. The first read of a dependent instruction comes in the cycle after the producer's final writeback.
- R6: Each granted instruction reads exactly as many elements as `vec_len` held in its grant cycle. It reads them in ascending order from index 0, at most one per unit per cycle, and later changes of `vec_len` do not affect it.
- R7: After the final writeback of an instruction, its unit takes no new grant for DEAD_CYC cycles. A waiting instruction is granted exactly DEAD_CYC+1 cycles after that writeback.
- R8: A register's busy flag and element count clear when its producer completes, so a new producer of that register starts counting from zero. A source equal to the instruction's own destination never blocks its reads.
- R9: While reset is applied, no read strobe is raised. After reset every unit is free and every register is idle.
- R10: The units work concurrently. Independent instructions are granted on consecutive cycles and read in the same cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| chain_en | input | 1 | 1: element-wise chaining, 0: wait for producer completion |
| vec_len | input | VLW | Vector length latched at grant (1..MAX_VL) |
| in_valid | input | 1 | Decoded instruction present |
| in_unit | input | 2 | Target unit: 0 load, 1 multiply, 2 add, 3 reserved |
| in_dst | input | RW | Destination vector register |
| in_src_a | input | RW | First source vector register |
| in_src_b | input | RW | Second source vector register |
| in_use_a | input | 1 | First source is read |
| in_use_b | input | 1 | Second source is read |
| grant | output | 1 | Instruction accepted this cycle |
| wb_pulse | input | 3 | Per-unit element writeback pulse (bit 0 load, 1 multiply, 2 add) |
| rd_en | output | 3 | Per-unit element read strobe |
| rd_elem | output | 3*VLW | Per-unit element index, unit u in bits [u*VLW +: VLW] |

## Verification
Two things can fall in the same cycle. A producer's final writeback can clear a register in the very cycle that a chained consumer asks to read from it or that a waiting instruction targets it. A grant to one unit can also coincide with element reads and completions on the other two. Random instruction streams over eight registers, with short and varied vector lengths, make such collisions frequent. The bench also feeds each unit's read strobes back as writebacks through its own latency pipeline. Every cycle's grant, read strobes and element indices are compared against an independent cycle-level model of the requirements. Directed cases pin the exact cycle offsets for chaining, waiting, dead time and both register hazards.

// File: rtl/vcs_pkg.sv
// Shared definitions for the vector chaining issue sequencer.
// Assumes exactly three functional units, coded on two bits.
package vcs_pkg;
    localparam int NUM_UNITS = 3;
    localparam int UNIT_W    = 2;

    typedef enum logic [UNIT_W-1:0] {
        UNIT_LOAD = 2'd0,
        UNIT_MUL  = 2'd1,
        UNIT_ADD  = 2'd2,
        UNIT_NONE = 2'd3
    } unit_e;
endpackage

// File: rtl/vcs_reg_track.sv
// Per-register occupancy tracker: one busy flag and one written-element count per register.
// Assumes set and clear never hit the same register in one cycle (set needs idle, clear needs busy).
module vcs_reg_track #(
    parameter int NREG = 8,
    parameter int RW   = 3,
    parameter int VLW  = 7
)(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            set_en,
    input  logic [RW-1:0]   set_idx,
    input  logic [NREG-1:0] inc_vec,
    input  logic [NREG-1:0] clr_vec,
    output logic [NREG-1:0] busy,
    output logic [VLW-1:0]  cnt [NREG]
);
    for (genvar r = 0; r < NREG; r++) begin : g_reg
        // Mark on producer grant, count writebacks, release on producer completion.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                busy[r] <= 1'b0;
                cnt[r]  <= '0;
            end else if (clr_vec[r]) begin
                busy[r] <= 1'b0;
                cnt[r]  <= '0;
            end else if (set_en && (set_idx == RW'(r))) begin
                busy[r] <= 1'b1;
                cnt[r]  <= '0;
            end else if (inc_vec[r]) begin
                cnt[r]  <= cnt[r] + 1'b1;
            end
        end
    end
endmodule

// File: rtl/vcs_fu_slot.sv
// Issue slot of one functional unit: holds the running instruction, steps its read index,
// counts its writebacks and enforces the dead time after completion.
// Assumes start is raised only while free is high and vector length is at least 1.
module vcs_fu_slot #(
    parameter int RW       = 3,
    parameter int VLW      = 7,
    parameter int DW       = 3,
    parameter int DEAD_CYC = 4
)(
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  logic [RW-1:0]  st_dst,
    input  logic [RW-1:0]  st_src_a,
    input  logic [RW-1:0]  st_src_b,
    input  logic           st_use_a,
    input  logic           st_use_b,
    input  logic [VLW-1:0] st_vl,
    input  logic           rd_go,
    input  logic           wb,
    output logic           active,
    output logic           free,
    output logic           reading,
    output logic           done,
    output logic [RW-1:0]  dst,
    output logic [RW-1:0]  src_a,
    output logic [RW-1:0]  src_b,
    output logic           use_a,
    output logic           use_b,
    output logic [VLW-1:0] rd_idx
);
    logic [VLW-1:0] vl_q;
    logic [VLW-1:0] wr_q;
    logic [DW-1:0]  dead_q;

    assign reading = active && (rd_idx < vl_q);
    assign free    = !active && (dead_q == '0);
    assign done    = active && wb && (VLW'(wr_q + 1'b1) == vl_q);

    // Load a new instruction, advance reads and writebacks, run the dead-time countdown.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0;
            vl_q   <= '0;
            rd_idx <= '0;
            wr_q   <= '0;
            dead_q <= '0;
            dst    <= '0;
            src_a  <= '0;
            src_b  <= '0;
            use_a  <= 1'b0;
            use_b  <= 1'b0;
        end else if (start) begin
            active <= 1'b1;
            vl_q   <= st_vl;
            rd_idx <= '0;
            wr_q   <= '0;
            dst    <= st_dst;
            src_a  <= st_src_a;
            src_b  <= st_src_b;
            use_a  <= st_use_a;
            use_b  <= st_use_b;
        end else begin
            if (rd_go)
                rd_idx <= rd_idx + 1'b1;
            if (done) begin
                active <= 1'b0;
                dead_q <= DW'(DEAD_CYC);
            end else begin
                if (wb && active)
                    wr_q <= wr_q + 1'b1;
                if (dead_q != '0)
                    dead_q <= dead_q - 1'b1;
            end
        end
    end
endmodule

// File: rtl/vcs_chain_seq.sv
// Vector chaining issue sequencer: in-order single issue to load, multiply and add units,
// with per-element source gating that either chains on written counts or waits for completion.
// Assumes writeback pulses come only for a unit's running instruction, one per element read.
module vcs_chain_seq
    import vcs_pkg::*;
#(
    parameter int NREG     = 8,
    parameter int MAX_VL   = 64,
    parameter int DEAD_CYC = 4
)(
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       chain_en,
    input  logic [$clog2(MAX_VL+1)-1:0] vec_len,
    input  logic                       in_valid,
    input  logic [UNIT_W-1:0]          in_unit,
    input  logic [$clog2(NREG)-1:0]    in_dst,
    input  logic [$clog2(NREG)-1:0]    in_src_a,
    input  logic [$clog2(NREG)-1:0]    in_src_b,
    input  logic                       in_use_a,
    input  logic                       in_use_b,
    output logic                       grant,
    input  logic [NUM_UNITS-1:0]       wb_pulse,
    output logic [NUM_UNITS-1:0]       rd_en,
    output logic [NUM_UNITS*$clog2(MAX_VL+1)-1:0] rd_elem
);
    localparam int RW  = $clog2(NREG);
    localparam int VLW = $clog2(MAX_VL + 1);
    localparam int DW  = $clog2(DEAD_CYC + 2);

    logic [NUM_UNITS-1:0] sl_active, sl_free, sl_reading, sl_done, sl_start;
    logic [NUM_UNITS-1:0] sl_use_a, sl_use_b, eff_a, eff_b;
    logic [RW-1:0]        sl_dst   [NUM_UNITS];
    logic [RW-1:0]        sl_src_a [NUM_UNITS];
    logic [RW-1:0]        sl_src_b [NUM_UNITS];
    logic [VLW-1:0]       sl_idx   [NUM_UNITS];
    logic [NREG-1:0]      reg_busy, reg_inc, reg_clr;
    logic [VLW-1:0]       reg_cnt  [NREG];
    logic [2**UNIT_W-1:0] free_pad;
    logic                 war_hit;
    unit_e                sel;

    assign sel      = unit_e'(in_unit);
    assign free_pad = (2**UNIT_W)'(sl_free);

    // Detect a destination that an unfinished reader still needs (write-after-read).
    always_comb begin
        war_hit = 1'b0;
        for (int u = 0; u < NUM_UNITS; u++) begin
            if (sl_reading[u] && ((sl_use_a[u] && (sl_src_a[u] == in_dst)) ||
                                  (sl_use_b[u] && (sl_src_b[u] == in_dst))))
                war_hit = 1'b1;
        end
    end

    // Grant the head instruction when its unit is free and its destination is clear.
    assign grant = in_valid && (sel != UNIT_NONE) && free_pad[in_unit] &&
                   !reg_busy[in_dst] && !war_hit;

    // Route writebacks and completions of each unit to its destination register.
    always_comb begin
        reg_inc = '0;
        reg_clr = '0;
        for (int r = 0; r < NREG; r++) begin
            for (int u = 0; u < NUM_UNITS; u++) begin
                if (sl_active[u] && (sl_dst[u] == RW'(r))) begin
                    if (wb_pulse[u]) reg_inc[r] = 1'b1;
                    if (sl_done[u])  reg_clr[r] = 1'b1;
                end
            end
        end
    end

    vcs_reg_track #(.NREG(NREG), .RW(RW), .VLW(VLW)) u_track (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_en  (grant),
        .set_idx (in_dst),
        .inc_vec (reg_inc),
        .clr_vec (reg_clr),
        .busy    (reg_busy),
        .cnt     (reg_cnt)
    );

    for (genvar u = 0; u < NUM_UNITS; u++) begin : g_unit
        logic ok_a, ok_b;

        assign sl_start[u] = grant && (in_unit == UNIT_W'(u));

        vcs_fu_slot #(.RW(RW), .VLW(VLW), .DW(DW), .DEAD_CYC(DEAD_CYC)) u_slot (
            .clk      (clk),
            .rst_n    (rst_n),
            .start    (sl_start[u]),
            .st_dst   (in_dst),
            .st_src_a (in_src_a),
            .st_src_b (in_src_b),
            .st_use_a (in_use_a),
            .st_use_b (in_use_b),
            .st_vl    (vec_len),
            .rd_go    (rd_en[u]),
            .wb       (wb_pulse[u]),
            .active   (sl_active[u]),
            .free     (sl_free[u]),
            .reading  (sl_reading[u]),
            .done     (sl_done[u]),
            .dst      (sl_dst[u]),
            .src_a    (sl_src_a[u]),
            .src_b    (sl_src_b[u]),
            .use_a    (sl_use_a[u]),
            .use_b    (sl_use_b[u]),
            .rd_idx   (sl_idx[u])
        );

        // An in-place source is read before the same element is rewritten, so it never blocks.
        assign eff_a[u] = sl_use_a[u] && (sl_src_a[u] != sl_dst[u]);
        assign eff_b[u] = sl_use_b[u] && (sl_src_b[u] != sl_dst[u]);

        // A source element is ready when the register is idle or, chaining, already written.
        assign ok_a = !eff_a[u] || !reg_busy[sl_src_a[u]] ||
                      (chain_en && (reg_cnt[sl_src_a[u]] > sl_idx[u]));
        assign ok_b = !eff_b[u] || !reg_busy[sl_src_b[u]] ||
                      (chain_en && (reg_cnt[sl_src_b[u]] > sl_idx[u]));

        assign rd_en[u] = sl_reading[u] && ok_a && ok_b;
        assign rd_elem[u*VLW +: VLW] = sl_idx[u];
    end
endmodule

// File: rtl/vcs_seq_chk.sv
// Property checker for the vector chaining issue sequencer, bound into every instance.
// Assumes the bound signals are the top's grant path, slot states and register tracker outputs.
module vcs_seq_chk #(
    parameter int NREG     = 8,
    parameter int RW       = 3,
    parameter int VLW      = 7,
    parameter int DW       = 3,
    parameter int DEAD_CYC = 4
)(
    input logic                 clk,
    input logic                 rst_n,
    input logic                 chain_en,
    input logic                 in_valid,
    input logic [1:0]           in_unit,
    input logic [RW-1:0]        in_dst,
    input logic                 grant,
    input logic [2:0]           rd_en,
    input logic [3*VLW-1:0]     rd_elem,
    input logic [2:0]           sl_done,
    input logic [2:0]           eff_a,
    input logic [2:0]           eff_b,
    input logic [RW-1:0]        sl_src_a [3],
    input logic [RW-1:0]        sl_src_b [3],
    input logic [NREG-1:0]      reg_busy
);
    AST_GRANT_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        grant |-> in_valid); // R1

    AST_RESERVED_UNIT: assert property (@(posedge clk) disable iff (!rst_n)
        (in_unit == 2'd3) |-> !grant); // R2

    AST_DST_IDLE_AT_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        grant |-> !reg_busy[in_dst]); // R3

    for (genvar u = 0; u < 3; u++) begin : g_chk
        logic [DW-1:0] gap;

        // Cycles since this unit last completed, saturating at the dead time.
        always_ff @(posedge clk) begin
            if (!rst_n)
                gap <= DW'(DEAD_CYC);
            else if (sl_done[u])
                gap <= '0;
            else if (gap < DW'(DEAD_CYC))
                gap <= gap + 1'b1;
        end

        AST_DEAD_GAP: assert property (@(posedge clk) disable iff (!rst_n)
            (grant && (in_unit == 2'(u))) |-> (gap == DW'(DEAD_CYC))); // R7

        AST_NOCHAIN_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
            (!chain_en && rd_en[u]) |->
                !((eff_a[u] && reg_busy[sl_src_a[u]]) ||
                  (eff_b[u] && reg_busy[sl_src_b[u]]))); // R5

        AST_ELEM_STEP: assert property (@(posedge clk) disable iff (!rst_n)
            rd_en[u] |=> (rd_elem[u*VLW +: VLW] == $past(rd_elem[u*VLW +: VLW]) + 1'b1)); // R6
    end
endmodule

bind vcs_chain_seq vcs_seq_chk #(
    .NREG(NREG), .RW(RW), .VLW(VLW), .DW(DW), .DEAD_CYC(DEAD_CYC)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .chain_en (chain_en),
    .in_valid (in_valid),
    .in_unit  (in_unit),
    .in_dst   (in_dst),
    .grant    (grant),
    .rd_en    (rd_en),
    .rd_elem  (rd_elem),
    .sl_done  (sl_done),
    .eff_a    (eff_a),
    .eff_b    (eff_b),
    .sl_src_a (sl_src_a),
    .sl_src_b (sl_src_b),
    .reg_busy (reg_busy)
);

// File: tb/vcs_chain_seq_test.sv
`timescale 1ns/1ps
module vcs_chain_seq_test;
    localparam int NREG = 8;
    localparam int MAX_VL = 64;
    localparam int DEAD = 4;
    localparam int RW = 3;
    localparam int VLW = 7;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic chain_en = 1'b0;
    logic [VLW-1:0] vec_len = '0;
    logic in_valid = 1'b0;
    logic [1:0] in_unit = '0;
    logic [RW-1:0] in_dst = '0, in_src_a = '0, in_src_b = '0;
    logic in_use_a = 1'b0, in_use_b = 1'b0;
    logic grant;
    logic [2:0] wb_pulse = '0;
    logic [2:0] rd_en;
    logic [3*VLW-1:0] rd_elem;

    always #4 clk = ~clk;

    vcs_chain_seq #(.NREG(NREG), .MAX_VL(MAX_VL), .DEAD_CYC(DEAD)) uut (
        .clk(clk), .rst_n(rst_n), .chain_en(chain_en), .vec_len(vec_len),
        .in_valid(in_valid), .in_unit(in_unit), .in_dst(in_dst),
        .in_src_a(in_src_a), .in_src_b(in_src_b), .in_use_a(in_use_a),
        .in_use_b(in_use_b), .grant(grant), .wb_pulse(wb_pulse),
        .rd_en(rd_en), .rd_elem(rd_elem)
    );

    int ncmp = 0, nbad = 0, cyc = 0;
    int lat [3] = '{2, 6, 4};
    // program
    int p_unit [64], p_dst [64], p_sa [64], p_sb [64], p_vl [64];
    bit p_ua [64], p_ub [64];
    int pn = 0, head = 0;
    // reference model
    bit b_act [3]; int b_idx [3], b_wr [3], b_vl [3], b_dead [3], b_dst [3], b_sa [3], b_sb [3], b_pid [3];
    bit b_ua [3], b_ub [3];
    bit b_busy [NREG]; int b_cnt [NREG];
    bit [7:0] pipe [3];
    // per-instruction timing record
    int grant_cyc [64], first_rd [64], first_wb [64], done_cyc [64], rd_count [64];
    bit overlap = 1'b0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        ncmp++;
        if (!ok) begin
            nbad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic bit src_ok(int s, bit use_s, int dst, int idx);
        return !use_s || (s == dst) || !b_busy[s] || (chain_en && (b_cnt[s] > idx));
    endfunction

    function automatic bit exp_grant();
        int u, d;
        u = p_unit[head]; d = p_dst[head];
        if (u > 2 || b_act[u] || b_dead[u] != 0 || b_busy[d]) return 1'b0;
        for (int k = 0; k < 3; k++)
            if (b_act[k] && b_idx[k] < b_vl[k] &&
                ((b_ua[k] && b_sa[k] == d) || (b_ub[k] && b_sb[k] == d))) return 1'b0;
        return 1'b1;
    endfunction

    task automatic add_ins(int u, int d, int sa, int sb, bit ua, bit ub, int vl);
        p_unit[pn] = u; p_dst[pn] = d; p_sa[pn] = sa; p_sb[pn] = sb;
        p_ua[pn] = ua; p_ub[pn] = ub; p_vl[pn] = vl; pn++;
    endtask

    task automatic step();
        bit eg; bit er [3]; bit wv [3]; int nrd;
        @(negedge clk);
        for (int u = 0; u < 3; u++) wv[u] = pipe[u][lat[u]-1];
        wb_pulse = {wv[2], wv[1], wv[0]};
        if (head < pn) begin
            in_valid = 1'b1; in_unit = 2'(p_unit[head]); in_dst = RW'(p_dst[head]);
            in_src_a = RW'(p_sa[head]); in_src_b = RW'(p_sb[head]);
            in_use_a = p_ua[head]; in_use_b = p_ub[head]; vec_len = VLW'(p_vl[head]);
        end else in_valid = 1'b0;
        #1;
        eg = (head < pn) && exp_grant();
        chk(grant === eg, "R1 grant", int'(grant), int'(eg));
        nrd = 0;
        for (int u = 0; u < 3; u++) begin
            er[u] = b_act[u] && (b_idx[u] < b_vl[u]) &&
                    src_ok(b_sa[u], b_ua[u], b_dst[u], b_idx[u]) &&
                    src_ok(b_sb[u], b_ub[u], b_dst[u], b_idx[u]);
            chk(rd_en[u] === er[u], chain_en ? "R4 read strobe" : "R5 read strobe",
                int'(rd_en[u]), int'(er[u]));
            if (er[u] && rd_en[u])
                chk(int'(rd_elem[u*VLW +: VLW]) == b_idx[u], "R6 element index",
                    int'(rd_elem[u*VLW +: VLW]), b_idx[u]);
            nrd += int'(rd_en[u]);
        end
        if (nrd >= 2) overlap = 1'b1;
        // advance model as at the coming edge
        for (int u = 0; u < 3; u++) if (b_dead[u] > 0) b_dead[u]--;
        for (int u = 0; u < 3; u++) if (er[u]) begin
            b_idx[u]++; rd_count[b_pid[u]]++;
            if (first_rd[b_pid[u]] < 0) first_rd[b_pid[u]] = cyc;
        end
        for (int u = 0; u < 3; u++) if (wv[u] && b_act[u]) begin
            b_cnt[b_dst[u]]++; b_wr[u]++;
            if (first_wb[b_pid[u]] < 0) first_wb[b_pid[u]] = cyc;
            if (b_wr[u] == b_vl[u]) begin
                b_act[u] = 1'b0; b_busy[b_dst[u]] = 1'b0; b_cnt[b_dst[u]] = 0;
                b_dead[u] = DEAD; done_cyc[b_pid[u]] = cyc;
            end
        end
        if (eg) begin
            int u;
            u = p_unit[head];
            b_act[u] = 1'b1; b_idx[u] = 0; b_wr[u] = 0; b_vl[u] = p_vl[head];
            b_dst[u] = p_dst[head]; b_sa[u] = p_sa[head]; b_sb[u] = p_sb[head];
            b_ua[u] = p_ua[head]; b_ub[u] = p_ub[head]; b_pid[u] = head;
            b_busy[p_dst[head]] = 1'b1; b_cnt[p_dst[head]] = 0;
            grant_cyc[head] = cyc; head++;
        end
        for (int u = 0; u < 3; u++) pipe[u] = {pipe[u][6:0], rd_en[u]};
        cyc++;
    endtask

    task automatic run_prog(bit ch);
        int n;
        chain_en = ch; head = 0; cyc = 0; n = 0;
        for (int i = 0; i < 64; i++) begin
            grant_cyc[i] = -1; first_rd[i] = -1; first_wb[i] = -1; done_cyc[i] = -1; rd_count[i] = 0;
        end
        do begin
            step(); n++;
        end while (n < 4000 && !(head == pn && !b_act[0] && !b_act[1] && !b_act[2] &&
                   pipe[0] == 0 && pipe[1] == 0 && pipe[2] == 0 &&
                   b_dead[0] == 0 && b_dead[1] == 0 && b_dead[2] == 0));
        chk(n < 4000, "R1 program drained", n, 4000);
        for (int i = 0; i < pn; i++)
            chk(rd_count[i] == p_vl[i], "R6 elements read per instruction", rd_count[i], p_vl[i]);
        pn = 0;
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", ncmp, nbad);
        $finish;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        ncmp++; nbad++;
        $display("FAIL R1 watchdog expired actual=%0d expected=%0d", 190000, 0);
        summary();
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int u = 0; u < 3; u++) begin b_act[u] = 0; b_dead[u] = 0; pipe[u] = '0; end
        for (int r = 0; r < NREG; r++) begin b_busy[r] = 0; b_cnt[r] = 0; end
        // R9: reset state
        repeat (3) @(negedge clk);
        #1;
        chk(rd_en === 3'b000, "R9 no reads in reset", int'(rd_en), 0);
        @(negedge clk); rst_n = 1'b1;
        #1;
        chk(rd_en === 3'b000, "R9 no reads after reset", int'(rd_en), 0);

        // R2: reserved unit code is never granted
        in_valid = 1'b1; in_unit = 2'd3; in_dst = 3'd1; vec_len = 7'd4;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk); #1;
            chk(grant === 1'b0, "R2 reserved unit held", int'(grant), 0);
        end
        in_valid = 1'b0;

        // R10: independent instructions on all three units
        add_ins(0, 1, 0, 0, 0, 0, 16); add_ins(1, 2, 3, 4, 1, 1, 16); add_ins(2, 5, 6, 7, 1, 1, 16);
        overlap = 1'b0;
        run_prog(1'b1);
        chk(grant_cyc[1] - grant_cyc[0] == 1, "R10 back-to-back grant", grant_cyc[1] - grant_cyc[0], 1);
        chk(grant_cyc[2] - grant_cyc[1] == 1, "R10 back-to-back grant", grant_cyc[2] - grant_cyc[1], 1);
        chk(overlap, "R10 concurrent reads", int'(overlap), 1);

        // R4: chained multiply follows first load writeback
        add_ins(0, 1, 0, 0, 0, 0, 8); add_ins(1, 3, 1, 2, 1, 1, 8);
        run_prog(1'b1);
        chk(first_rd[1] - first_wb[0] == 1, "R4 chained start", first_rd[1] - first_wb[0], 1);

        // R5: without chaining the multiply waits for the last load writeback
        add_ins(0, 1, 0, 0, 0, 0, 8); add_ins(1, 3, 1, 2, 1, 1, 8);
        run_prog(1'b0);
        chk(first_rd[1] - done_cyc[0] == 1, "R5 unchained start", first_rd[1] - done_cyc[0], 1);

        // R7: dead time between two loads
        add_ins(0, 1, 0, 0, 0, 0, 4); add_ins(0, 2, 0, 0, 0, 0, 4);
        run_prog(1'b1);
        chk(grant_cyc[1] - done_cyc[0] == DEAD + 1, "R7 dead time", grant_cyc[1] - done_cyc[0], DEAD + 1);

        // R3: write-after-write waits for producer completion
        add_ins(0, 1, 0, 0, 0, 0, 8); add_ins(2, 1, 2, 3, 1, 1, 8);
        run_prog(1'b1);
        chk(grant_cyc[1] - done_cyc[0] == 1, "R3 WAW stall", grant_cyc[1] - done_cyc[0], 1);

        // R3: write-after-read waits until the reader has read every element
        add_ins(1, 4, 5, 6, 1, 1, 8); add_ins(0, 5, 0, 0, 0, 0, 4);
        run_prog(1'b1);
        chk(grant_cyc[1] - grant_cyc[0] == 9, "R3 WAR stall", grant_cyc[1] - grant_cyc[0], 9);

        // R8: in-place source does not block
        add_ins(2, 2, 2, 3, 1, 1, 4);
        run_prog(1'b0);
        chk(first_rd[0] - grant_cyc[0] == 1, "R8 in-place read", first_rd[0] - grant_cyc[0], 1);

        // R8: a re-produced register counts again from zero
        add_ins(0, 1, 0, 0, 0, 0, 4); add_ins(0, 1, 0, 0, 0, 0, 4); add_ins(2, 5, 1, 1, 1, 1, 4);
        run_prog(1'b1);
        chk(first_rd[2] - first_wb[1] == 1, "R8 count restarts", first_rd[2] - first_wb[1], 1);

        // R6: long vector at the maximum length, then random streams
        add_ins(0, 1, 0, 0, 0, 0, MAX_VL); add_ins(1, 2, 1, 1, 1, 1, 3);
        run_prog(1'b1);
        for (int t = 0; t < 40; t++) begin
            int n;
            n = 8 + int'($urandom % 16);
            for (int i = 0; i < n; i++) begin
                int u;
                u = int'($urandom % 3);
                add_ins(u, int'($urandom % NREG), int'($urandom % NREG), int'($urandom % NREG),
                        u != 0, (u != 0) && ($urandom % 2 == 0),
                        ($urandom % 16 == 0) ? MAX_VL : 1 + int'($urandom % 12));
            end
            run_prog(bit'($urandom % 2));
        end
        summary();
    end
endmodule